// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of a synchronous DRAM read or write burst. A controller pulses a start input with a starting column and an auto-precharge flag. On each following cycle, the sequencer presents the column of the current beat and marks it valid. It computes the beat order from a captured mode word. That word carries a length code, an ordering bit (linear or XOR-interleaved) and a CAS-latency bit.

A burst ends in one of four ways:
- It runs out at its programmed length.
- A stop command cuts it short.
- A same-bank precharge cuts it short.
- A new column command replaces it with a fresh burst from the given column.

New column commands are accepted every cycle, so the column can change on every beat. After a stop or precharge, a tail flag stays high for as many cycles as data keeps flowing at the captured CAS latency. A burst opened with auto-precharge may not be interrupted by a column command or a precharge. Such attempts are flagged and have no other effect.

The mode word field positions are as follows:
- Bits 2:0 hold the length code.
- Bit 3 holds the ordering (0 linear, 1 interleaved).
- Bit 4 holds the latency (0 for CAS latency 2, 1 for CAS latency 3).

Top module: `sdram_col_seq`

## Requirements
- R1: While reset is held and after it is released, `beat_vld_o`, `done_o`, `tail_vld_o` and `ap_err_o` are 0. `col_o` is 0 whenever no beat is valid.
- R2: With ordering bit 0 and length 4 or 8, beat k (counted from 0) has low log2(BL) bits equal to (start + k) mod BL. The upper column bits equal those of the start column.
- R3: With ordering bit 1 and length 4 or 8, beat k has low log2(BL) bits equal to start XOR k. The upper column bits are held.
- R4: With length 1 or 2, the beat sequence is the same for both values of the ordering bit.
- R5: The length code maps 000 to 1 beat, 001 to 2, 010 to 4, 011 to 8 and 111 to a full page.
  - A burst of length BL starts one cycle after the start pulse and gives BL valid beats.
  - `done_o` is 1 exactly on the last one.
  - A start pulse carrying any other code starts no burst.
- R6: A full-page burst steps the 9-bit column by one per beat, wrapping from 511 to 0. It never asserts `done_o` by itself and runs until terminated.
- R7: A stop pulse during a burst has the following effects:
  - `beat_vld_o` drops in the next cycle.
  - `done_o` is 1 for that one cycle.
  - `tail_vld_o` is 1 for 1 cycle at CAS latency 2, or 2 cycles at CAS latency 3.
- R8: A column command during a burst without auto-precharge makes the next cycle's beat the new column at beat index 0. It restarts the programmed length from there. Such commands may come on consecutive cycles.
- R9: A precharge pulse during a burst without auto-precharge ends it with the same next-cycle behaviour and latency tail as R7.
- R10: During a burst started with auto-precharge, a column command or precharge raises `ap_err_o` for one cycle in the next cycle. The burst's addresses and length continue unchanged.
- R11: The mode word is captured only when a burst starts. Changes while a burst runs do not alter it.
- R12: A start pulse while a burst is running is ignored.
- R13: When stop or precharge coincides with a column command, the termination wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Length code, ordering bit, latency bit |
| start_i | input | 1 | Begin a burst (used only when idle) |
| start_col_i | input | 9 | Starting column |
| start_ap_i | input | 1 | Burst carries auto-precharge |
| stop_i | input | 1 | Burst stop command |
| cas_i | input | 1 | Interrupting read/write command |
| cas_col_i | input | 9 | Column of the interrupting command |
| pre_i | input | 1 | Same-bank precharge |
| col_o | output | 9 | Column of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| done_o | output | 1 | Last beat, or cycle after termination |
| tail_vld_o | output | 1 | Data still flowing after a stop or precharge |
| ap_err_o | output | 1 | Illegal interrupt of an auto-precharge burst |

## Verification
The assertions assume that command pulses are sampled only on clock edges after the synchronised reset release. They also assume the controller issues a stop, precharge or column command only in relation to the burst the block itself reports. Simultaneous commands are resolved inside the block, so the properties condition on which inputs are high rather than forbidding overlap. The stimulus changes every input on the falling edge and pulses commands for exactly one rising edge, except where back-to-back column commands are the point of the test. It only checks outputs on falling edges after the registers have settled.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  typedef enum logic [2:0] {
    LEN_1  = 3'b000,
    LEN_2  = 3'b001,
    LEN_4  = 3'b010,
    LEN_8  = 3'b011,
    LEN_PG = 3'b111
  } len_code_e;

  localparam int MODE_W   = 5;
  localparam int ORD_BIT  = 3;
  localparam int CL3_BIT  = 4;
endpackage

// File: rtl/col_mode_dec.sv
module col_mode_dec
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic [COL_W-1:0]  mask_o,
  output logic              full_o,
  output logic              ok_o,
  output logic              ord_o,
  output logic              cl3_o
);
  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    ok_o   = 1'b1;
    case (mode_i[2:0])
      LEN_1:   mask_o = '0;
      LEN_2:   mask_o = COL_W'(1);
      LEN_4:   mask_o = COL_W'(3);
      LEN_8:   mask_o = COL_W'(7);
      LEN_PG:  begin
        mask_o = '1;
        full_o = 1'b1;
      end
      default: ok_o = 1'b0;
    endcase
  end

  assign ord_o = mode_i[ORD_BIT];
  assign cl3_o = mode_i[CL3_BIT];
endmodule

// File: rtl/col_addr_gen.sv
module col_addr_gen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o
);
  logic [COL_W-1:0] lin;
  logic [COL_W-1:0] pick;

  always_comb begin
    lin    = base_i + idx_i;
    pick   = ilv_i ? (base_i ^ idx_i) : lin;
    addr_o = (base_i & ~mask_i) | (pick & mask_i);
  end
endmodule

// File: rtl/col_tail_cnt.sv
module col_tail_cnt #(
  parameter int TAIL_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic cl3_i,
  output logic vld_o
);
  logic [TAIL_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_d = cl3_i ? TAIL_W'(2) : TAIL_W'(1);
    else        cnt_d = cnt_q - TAIL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign vld_o = (cnt_q != '0);
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int TAIL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              start_ap_i,
  input  logic              stop_i,
  input  logic              cas_i,
  input  logic [COL_W-1:0]  cas_col_i,
  input  logic              pre_i,
  output logic [COL_W-1:0]  col_o,
  output logic              beat_vld_o,
  output logic              done_o,
  output logic              tail_vld_o,
  output logic              ap_err_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  // decoded mode of the live input
  logic [COL_W-1:0] dec_mask;
  logic             dec_full, dec_ok, dec_ord, dec_cl3;

  col_mode_dec #(.COL_W(COL_W)) i_dec (
    .mode_i (mode_i),
    .mask_o (dec_mask),
    .full_o (dec_full),
    .ok_o   (dec_ok),
    .ord_o  (dec_ord),
    .cl3_o  (dec_cl3)
  );

  // burst state
  logic             act_q, act_d;
  logic             ap_q, ap_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] idx_q, idx_d;
  logic [COL_W-1:0] mask_q;
  logic             full_q, ord_q, cl3_q;
  logic             term_q, err_q;

  logic acc_start, terminate, restart, last_beat, ap_viol, st_en;

  always_comb begin
    acc_start = start_i && !act_q && dec_ok;
    terminate = act_q && (stop_i || (pre_i && !ap_q));
    restart   = act_q && cas_i && !ap_q && !terminate;
    last_beat = act_q && !full_q && (idx_q == mask_q);
    ap_viol   = act_q && ap_q && (cas_i || pre_i);
    st_en     = acc_start || act_q;

    act_d  = act_q;
    ap_d   = ap_q;
    base_d = base_q;
    idx_d  = idx_q;
    if (acc_start) begin
      act_d  = 1'b1;
      ap_d   = start_ap_i;
      base_d = start_col_i;
      idx_d  = '0;
    end else if (terminate) begin
      act_d  = 1'b0;
    end else if (restart) begin
      ap_d   = 1'b0;
      base_d = cas_col_i;
      idx_d  = '0;
    end else if (last_beat) begin
      act_d  = 1'b0;
    end else begin
      idx_d  = idx_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      act_q  <= 1'b0;
      ap_q   <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
    end else if (st_en) begin
      act_q  <= act_d;
      ap_q   <= ap_d;
      base_q <= base_d;
      idx_q  <= idx_d;
    end
  end

  // mode captured only at burst start
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mask_q <= '0;
      full_q <= 1'b0;
      ord_q  <= 1'b0;
      cl3_q  <= 1'b0;
    end else if (acc_start) begin
      mask_q <= dec_mask;
      full_q <= dec_full;
      ord_q  <= dec_ord;
      cl3_q  <= dec_cl3;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      term_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      term_q <= terminate;
      err_q  <= ap_viol;
    end
  end

  logic [COL_W-1:0] beat_addr;
  col_addr_gen #(.COL_W(COL_W)) i_addr (
    .base_i (base_q),
    .idx_i  (idx_q),
    .mask_i (mask_q),
    .ilv_i  (ord_q && !full_q),
    .addr_o (beat_addr)
  );

  col_tail_cnt #(.TAIL_W(TAIL_W)) i_tail (
    .clk    (clk),
    .rst_n  (rst_s),
    .load_i (terminate),
    .cl3_i  (cl3_q),
    .vld_o  (tail_vld_o)
  );

  assign beat_vld_o = act_q;
  assign col_o      = act_q ? beat_addr : '0;
  assign done_o     = last_beat || term_q;
  assign ap_err_o   = err_q;

  // assertions
  p_idle_col_r1: assert property (@(posedge clk) disable iff (!rst_s)
    !beat_vld_o |-> (col_o == '0));

  p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (beat_vld_o && done_o && !stop_i && !pre_i && !cas_i) |=> !beat_vld_o);

  p_page_wrap_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (act_q && full_q && !stop_i && !pre_i && !cas_i && (col_o == '1))
      |=> (beat_vld_o && col_o == '0 && !done_o));

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (beat_vld_o && stop_i) |=> (!beat_vld_o && done_o && tail_vld_o));

  p_cas_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (beat_vld_o && cas_i && !ap_q && !stop_i && !pre_i)
      |=> (beat_vld_o && col_o == $past(cas_col_i)));

  p_ap_flag_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (beat_vld_o && ap_q && (cas_i || pre_i) && !stop_i)
      |=> (ap_err_o && $stable(base_q)));
endmodule

// File: tb/test_sdram_col_seq.sv
module test_sdram_col_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 9;

  logic             clk;
  logic             rst_n;
  logic [4:0]       mode_i;
  logic             start_i, start_ap_i, stop_i, cas_i, pre_i;
  logic [COL_W-1:0] start_col_i, cas_col_i;
  logic [COL_W-1:0] col_o;
  logic             beat_vld_o, done_o, tail_vld_o, ap_err_o;

  int total = 0;
  int bad = 0;

  sdram_col_seq i_sdram_col_seq (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .start_i(start_i),
    .start_col_i(start_col_i), .start_ap_i(start_ap_i), .stop_i(stop_i),
    .cas_i(cas_i), .cas_col_i(cas_col_i), .pre_i(pre_i), .col_o(col_o),
    .beat_vld_o(beat_vld_o), .done_o(done_o), .tail_vld_o(tail_vld_o),
    .ap_err_o(ap_err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [4:0] mk(input logic [2:0] code, input logic ord, input logic cl3);
    return {cl3, ord, code};
  endfunction

  function automatic int blen(input logic [2:0] code);
    case (code)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 512;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int k, input logic [2:0] code, input logic ord);
    int bl = blen(code);
    if (bl == 512) return (s + k) % 512;
    if (ord && bl >= 4) return (s & ~(bl-1)) | ((s ^ k) & (bl-1));
    return (s & ~(bl-1)) | ((s + k) % bl);
  endfunction

  task automatic begin_burst(input logic [4:0] m, input int c, input logic ap);
    mode_i = m; start_col_i = COL_W'(c); start_ap_i = ap; start_i = 1'b1;
    step();
    start_i = 1'b0; start_ap_i = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    chk(!beat_vld_o && !done_o && !tail_vld_o && !ap_err_o && col_o == 0,
        "R1", int'(beat_vld_o), 0);
  endtask

  // R2 R3 R4 R5
  task automatic t_fixed(input logic [2:0] code, input logic ord, input int c, input string req);
    int bl = blen(code);
    begin_burst(mk(code, ord, 1'b0), c, 1'b0);
    for (int k = 0; k < bl; k++) begin
      chk(beat_vld_o && col_o == exp_col(c, k, code, ord), req, int'(col_o), exp_col(c, k, code, ord));
      chk(done_o == (k == bl-1), "R5", int'(done_o), int'(k == bl-1));
      step();
    end
    chk(!beat_vld_o, "R5", int'(beat_vld_o), 0);
  endtask

  // R5 reserved code
  task automatic t_reserved();
    begin_burst(mk(3'b100, 1'b0, 1'b0), 7, 1'b0);
    chk(!beat_vld_o, "R5", int'(beat_vld_o), 0);
    step();
    chk(!beat_vld_o, "R5", int'(beat_vld_o), 0);
  endtask

  // R6 then R7 at latency 2
  task automatic t_fullpage();
    begin_burst(mk(3'b111, 1'b1, 1'b0), 500, 1'b0);
    for (int k = 0; k < 600; k++) begin
      chk(beat_vld_o && !done_o && col_o == (500 + k) % 512, "R6", int'(col_o), (500 + k) % 512);
      step();
    end
    stop_i = 1'b1;
    step();
    stop_i = 1'b0;
    chk(!beat_vld_o && done_o && tail_vld_o, "R7", int'(tail_vld_o), 1);
    step();
    chk(!done_o && !tail_vld_o, "R7", int'(tail_vld_o), 0);
  endtask

  // R7 at latency 3, or R9 with precharge; sel_pre chooses
  task automatic t_term(input logic sel_pre, input logic cl3, input string req);
    begin_burst(mk(3'b011, 1'b0, cl3), 8, 1'b0);
    for (int k = 0; k < 3; k++) begin
      chk(col_o == 8 + k, req, int'(col_o), 8 + k);
      step();
    end
    if (sel_pre) pre_i = 1'b1; else stop_i = 1'b1;
    cas_i = 1'b1; cas_col_i = 9'h0AA;   // R13: termination wins over the column command
    step();
    pre_i = 1'b0; stop_i = 1'b0; cas_i = 1'b0;
    chk(!beat_vld_o && done_o && tail_vld_o, req, int'(beat_vld_o), 0);
    chk(!beat_vld_o, "R13", int'(beat_vld_o), 0);
    step();
    chk(!done_o && tail_vld_o == cl3, req, int'(tail_vld_o), int'(cl3));
    step();
    chk(!tail_vld_o && !beat_vld_o, req, int'(tail_vld_o), 0);
  endtask

  // R8
  task automatic t_cas();
    begin_burst(mk(3'b010, 1'b0, 1'b0), 5, 1'b0);
    chk(col_o == 5, "R8", int'(col_o), 5);
    cas_i = 1'b1; cas_col_i = 9'h040;
    step();
    chk(beat_vld_o && col_o == 9'h040 && !done_o, "R8", int'(col_o), 'h40);
    cas_col_i = 9'h081;
    step();
    chk(col_o == 9'h081, "R8", int'(col_o), 'h81);
    cas_col_i = 9'h1C3;
    step();
    cas_i = 1'b0;
    chk(col_o == 9'h1C3, "R8", int'(col_o), 'h1C3);
    for (int k = 1; k < 4; k++) begin
      step();
      chk(beat_vld_o && col_o == exp_col('h1C3, k, 3'b010, 1'b0) && done_o == (k == 3),
          "R8", int'(col_o), exp_col('h1C3, k, 3'b010, 1'b0));
    end
    step();
    chk(!beat_vld_o, "R8", int'(beat_vld_o), 0);
  endtask

  // R10
  task automatic t_ap();
    begin_burst(mk(3'b010, 1'b0, 1'b1), 'h10, 1'b1);
    chk(col_o == 'h10 && !ap_err_o, "R10", int'(col_o), 'h10);
    pre_i = 1'b1;
    step();
    pre_i = 1'b0;
    chk(ap_err_o && beat_vld_o && col_o == 'h11 && !tail_vld_o, "R10", int'(col_o), 'h11);
    cas_i = 1'b1; cas_col_i = 9'h055;
    step();
    cas_i = 1'b0;
    chk(ap_err_o && col_o == 'h12, "R10", int'(col_o), 'h12);
    step();
    chk(!ap_err_o && col_o == 'h13 && done_o, "R10", int'(col_o), 'h13);
    step();
    chk(!beat_vld_o, "R10", int'(beat_vld_o), 0);
  endtask

  // R11 R12
  task automatic t_mode_hold();
    begin_burst(mk(3'b010, 1'b0, 1'b0), 'h22, 1'b0);
    chk(col_o == 'h22, "R11", int'(col_o), 'h22);
    mode_i = mk(3'b000, 1'b1, 1'b1);
    start_i = 1'b1; start_col_i = 9'h099;
    step();
    start_i = 1'b0;
    for (int k = 1; k < 4; k++) begin
      chk(beat_vld_o && col_o == exp_col('h22, k, 3'b010, 1'b0), "R12", int'(col_o),
          exp_col('h22, k, 3'b010, 1'b0));
      chk(done_o == (k == 3), "R11", int'(done_o), int'(k == 3));
      step();
    end
    chk(!beat_vld_o, "R11", int'(beat_vld_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_i = '0; start_i = 0; start_col_i = '0; start_ap_i = 0;
    stop_i = 0; cas_i = 0; cas_col_i = '0; pre_i = 0;
    step(); step();
    t_reset();
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step();
    t_reset();
    t_fixed(3'b010, 1'b0, 'h0A6, "R2");
    t_fixed(3'b011, 1'b0, 'h15D, "R2");
    t_fixed(3'b010, 1'b1, 'h0A6, "R3");
    t_fixed(3'b011, 1'b1, 'h15D, "R3");
    t_fixed(3'b000, 1'b1, 'h033, "R4");
    t_fixed(3'b001, 1'b0, 'h033, "R4");
    t_fixed(3'b001, 1'b1, 'h033, "R4");
    t_reserved();
    t_fullpage();
    t_term(1'b0, 1'b1, "R7");
    t_term(1'b1, 1'b0, "R9");
    t_term(1'b1, 1'b1, "R9");
    t_cas();
    t_ap();
    t_mode_hold();
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule